// File: doc/BRIEF.md
# Video Timing Word Aligner

This block sits behind a deserializer that delivers 20-bit words with an unknown word boundary. It combines each accepted word with the one before it and takes a 20-bit slice at a 5-bit offset. It then watches the sliced stream for the four-word timing reference: all ones, zero, zero, then a flag word. If a whole line period passes with no reference at the current offset, the offset moves by one bit and the search starts again. The first reference found sets the locked flag.

While aligned, the block presents the sliced words with a qualifier. Beside each word it gives three strobes: a once-per-line pulse on the second line-number word, a frame pulse on that same word when the line number is 1, and a horizontal-ancillary flag that covers the blanking words between the end-of-line checksum and the next timing reference. A low enable freezes the block and holds all of its indicators low.

Top module: `vid_word_aligner`

## Requirements
- R1: After reset the offset is 0, and locked_o, slip_o, data_vld_o, line_o, frame_o and hanc_o are all low.
- R2: A word is accepted when word_vld_i and en_i are both high. In the following cycle data_o holds bits off..off+19 of {word_i, previous accepted word}, where bit 0 is the earliest bit in time, and data_vld_o is high.
- R3: A timing reference is four consecutive aligned words: 20'hFFFFF, 20'h00000, 20'h00000, and a flag word whose two 10-bit halves are equal and whose bit 9 is set. Detecting one sets locked_o from the next cycle and restarts the line timer.
- R4: While unlocked, LINE_WORDS accepted words with no reference advance the offset by one bit, give a one-cycle slip_o pulse, and discard the partial reference history.
- R5: The offset runs from 0 to 19 and wraps from 19 back to 0.
- R6: While locked, two consecutive line periods with no reference clear locked_o and leave the offset unchanged. The search then continues from that offset.
- R7: line_o is high only with the second word after a flag word whose bit 6 is set (an end-of-active reference), once per such reference.
- R8: frame_o is high only together with line_o, and only when the line number {LN1[5:2], LN0[8:2]} equals 1. LN0 is the first word after the end-of-active flag word.
- R9: hanc_o is high for each word after the fourth word that follows an end-of-active flag word, up to but not including the next word equal to 20'hFFFFF. It is low on timing words.
- R10: While en_i is low, incoming words are ignored with no change of state, and data_vld_o, line_o, frame_o and hanc_o stay low.
- R11: Cycles with word_vld_i low change neither the offset, the timers nor the line position, and give data_vld_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Block enable |
| word_vld_i | input | 1 | Raw word qualifier |
| word_i | input | 20 | Raw word from the deserializer, bit 0 first in time |
| data_o | output | 20 | Aligned word |
| data_vld_o | output | 1 | Aligned word qualifier |
| locked_o | output | 1 | Alignment found |
| slip_o | output | 1 | One-cycle pulse after each one-bit boundary move |
| line_o | output | 1 | Once-per-line strobe |
| frame_o | output | 1 | First-line-of-frame strobe |
| hanc_o | output | 1 | Horizontal ancillary word flag |

## Verification
Several properties are checked on every cycle by assertions. The offset stays in range and steps by exactly one with wrap on each slip. Slips happen only while unlocked. A detected reference always leads to lock. Losing lock never moves the offset. Idle or disabled cycles freeze the offset. The strobes stay quiet while disabled, the frame strobe only appears with the line strobe, and the ancillary flag never marks an all-ones word. Other properties depend on long stimulus and only the bench scenarios can show them: the number of slips needed to reach a given bit phase, recovery through the 19-to-0 wrap after lock loss, the exact length of each ancillary run, and line and frame counts for line numbers whose low bits alone would look like line 1.

// File: rtl/vwa_pkg.sv
package vwa_pkg;
  localparam int HALF_W  = 10;
  localparam int WORD_W  = 2 * HALF_W;
  localparam int OFF_W   = $clog2(WORD_W);
  localparam int TRS_LEN = 4;
  localparam int HIST_N  = TRS_LEN - 1;
  localparam int FILL_W  = $clog2(TRS_LEN);
  localparam int LN_LO_W = 7;
  localparam int LN_W    = 11;

  typedef logic [WORD_W-1:0] word_t;
  localparam word_t ALL_ONES = '1;

  function automatic logic is_flag_word(word_t w);
    return (w[WORD_W-1:HALF_W] == w[HALF_W-1:0]) && w[HALF_W-1];
  endfunction

  function automatic logic flag_is_eav(word_t w);
    return w[6];
  endfunction

  function automatic logic [LN_W-1:0] line_number(logic [LN_LO_W-1:0] lo, word_t ln1);
    return {ln1[5:2], lo};
  endfunction

  function automatic logic [OFF_W-1:0] next_off(logic [OFF_W-1:0] o);
    return (o == OFF_W'(WORD_W - 1)) ? '0 : o + 1'b1;
  endfunction
endpackage

// File: rtl/vwa_shifter.sv
module vwa_shifter
  import vwa_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  word_t            word_i,
  input  logic [OFF_W-1:0] off_i,
  output word_t            aligned_o
);
  word_t                prev_q;
  logic [2*WORD_W-1:0]  win;
  word_t                cand [WORD_W];

  always_ff @(posedge clk_i) begin
    if (!rst_ni)    prev_q <= '0;
    else if (acc_i) prev_q <= word_i;
  end

  assign win = {word_i, prev_q};

  // one candidate slice per possible bit boundary (R2)
  for (genvar k = 0; k < WORD_W; k++) begin : g_cand
    assign cand[k] = win[k +: WORD_W];
  end

  always_comb begin
    aligned_o = cand[0];
    for (int k = 0; k < WORD_W; k++)
      if (off_i == OFF_W'(k)) aligned_o = cand[k];
  end
endmodule

// File: rtl/vwa_trs_detect.sv
module vwa_trs_detect
  import vwa_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  acc_i,
  input  logic  flush_i,
  input  word_t aligned_i,
  output logic  hit_o,
  output logic  eav_o
);
  word_t             hist_q [HIST_N];
  logic [FILL_W-1:0] fill_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                                fill_q <= '0;
    else if (flush_i)                           fill_q <= '0;
    else if (acc_i && fill_q != FILL_W'(HIST_N)) fill_q <= fill_q + 1'b1;
  end

  for (genvar i = 0; i < HIST_N; i++) begin : g_hist
    always_ff @(posedge clk_i) begin
      if (!rst_ni)    hist_q[i] <= '0;
      else if (acc_i) hist_q[i] <= (i == 0) ? aligned_i : hist_q[(i == 0) ? 0 : i - 1];
    end
  end

  // hist_q[0] newest: ones, zero, zero, then the flag word now (R3)
  assign hit_o = acc_i && (fill_q == FILL_W'(HIST_N)) &&
                 (hist_q[2] == ALL_ONES) && (hist_q[1] == '0) && (hist_q[0] == '0) &&
                 is_flag_word(aligned_i);
  assign eav_o = hit_o && flag_is_eav(aligned_i);
endmodule

// File: rtl/vwa_search_ctrl.sv
module vwa_search_ctrl
  import vwa_pkg::*;
#(
  parameter int LINE_WORDS = 2200,
  parameter int MISS_LIMIT = 2,
  localparam int GAP_W  = $clog2(LINE_WORDS),
  localparam int MISS_W = $clog2(MISS_LIMIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             hit_i,
  output logic [OFF_W-1:0] off_o,
  output logic             locked_o,
  output logic             slip_o,
  output logic             slip_now_o,
  output logic [GAP_W-1:0] gap_o
);
  logic [OFF_W-1:0]  off_q;
  logic [GAP_W-1:0]  gap_q;
  logic [MISS_W-1:0] miss_q;
  logic              locked_q, slip_q, timeout;

  assign timeout    = acc_i && !hit_i && (gap_q == GAP_W'(LINE_WORDS - 1));
  assign slip_now_o = timeout && !locked_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      off_q <= '0; gap_q <= '0; miss_q <= '0; locked_q <= 1'b0; slip_q <= 1'b0;
    end else begin
      slip_q <= slip_now_o;                       // R4
      if (acc_i) begin
        if (hit_i) begin                          // R3
          gap_q <= '0; miss_q <= '0; locked_q <= 1'b1;
        end else if (timeout) begin
          gap_q <= '0;
          if (!locked_q) off_q <= next_off(off_q); // R5
          else if (miss_q == MISS_W'(MISS_LIMIT - 1)) begin
            locked_q <= 1'b0; miss_q <= '0;       // R6
          end else miss_q <= miss_q + 1'b1;
        end else gap_q <= gap_q + 1'b1;
      end
    end
  end

  assign off_o    = off_q;
  assign locked_o = locked_q;
  assign slip_o   = slip_q;
  assign gap_o    = gap_q;
endmodule

// File: rtl/vwa_line_flags.sv
module vwa_line_flags
  import vwa_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  acc_i,
  input  logic  flush_i,
  input  logic  eav_i,
  input  word_t aligned_i,
  output word_t data_o,
  output logic  vld_o,
  output logic  line_o,
  output logic  frame_o,
  output logic  hanc_o
);
  logic [2:0]         pos_q;
  logic               hanc_st_q;
  logic [LN_LO_W-1:0] lnlo_q;
  logic               is_trs_start;

  assign is_trs_start = (aligned_i == ALL_ONES);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      data_o <= '0; vld_o <= 1'b0; line_o <= 1'b0; frame_o <= 1'b0; hanc_o <= 1'b0;
      pos_q <= '0; hanc_st_q <= 1'b0; lnlo_q <= '0;
    end else if (acc_i) begin
      data_o  <= aligned_i;
      vld_o   <= 1'b1;
      line_o  <= (pos_q == 3'd2);                                                // R7
      frame_o <= (pos_q == 3'd2) && (line_number(lnlo_q, aligned_i) == LN_W'(1)); // R8
      hanc_o  <= hanc_st_q && !is_trs_start;                                     // R9
      if (pos_q == 3'd1) lnlo_q <= aligned_i[8:2];
      if (flush_i) begin
        pos_q <= '0; hanc_st_q <= 1'b0;
      end else begin
        if (pos_q == 3'd4)     hanc_st_q <= 1'b1;
        else if (is_trs_start) hanc_st_q <= 1'b0;
        if (eav_i)             pos_q <= 3'd1;
        else if (pos_q == 3'd4) pos_q <= '0;
        else if (pos_q != '0)  pos_q <= pos_q + 1'b1;
      end
    end else begin
      vld_o <= 1'b0; line_o <= 1'b0; frame_o <= 1'b0; hanc_o <= 1'b0;          // R11
    end
  end
endmodule

// File: rtl/vid_word_aligner.sv
module vid_word_aligner
  import vwa_pkg::*;
#(
  parameter int LINE_WORDS = 2200,
  parameter int MISS_LIMIT = 2,
  localparam int GAP_W = $clog2(LINE_WORDS)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        word_vld_i,
  input  logic [19:0] word_i,
  output logic [19:0] data_o,
  output logic        data_vld_o,
  output logic        locked_o,
  output logic        slip_o,
  output logic        line_o,
  output logic        frame_o,
  output logic        hanc_o
);
  logic             acc_w, hit_w, eav_w, slip_now_w;
  logic [OFF_W-1:0] off_w;
  logic [GAP_W-1:0] gap_w;
  word_t            aligned_w;
  logic             vld_q, line_q, frame_q, hanc_q;

  assign acc_w = word_vld_i && en_i; // R10 R11

  vwa_shifter u_shift (
    .clk_i, .rst_ni, .acc_i(acc_w), .word_i, .off_i(off_w), .aligned_o(aligned_w)
  );

  vwa_trs_detect u_det (
    .clk_i, .rst_ni, .acc_i(acc_w), .flush_i(slip_now_w), .aligned_i(aligned_w),
    .hit_o(hit_w), .eav_o(eav_w)
  );

  vwa_search_ctrl #(.LINE_WORDS(LINE_WORDS), .MISS_LIMIT(MISS_LIMIT)) u_srch (
    .clk_i, .rst_ni, .acc_i(acc_w), .hit_i(hit_w), .off_o(off_w), .locked_o,
    .slip_o, .slip_now_o(slip_now_w), .gap_o(gap_w)
  );

  vwa_line_flags u_flags (
    .clk_i, .rst_ni, .acc_i(acc_w), .flush_i(slip_now_w), .eav_i(eav_w),
    .aligned_i(aligned_w), .data_o, .vld_o(vld_q), .line_o(line_q),
    .frame_o(frame_q), .hanc_o(hanc_q)
  );

  assign data_vld_o = vld_q   && en_i;
  assign line_o     = line_q  && en_i;
  assign frame_o    = frame_q && en_i;
  assign hanc_o     = hanc_q  && en_i;
endmodule

// File: rtl/vwa_checker.sv
module vwa_checker
  import vwa_pkg::*;
#(
  parameter int LINE_WORDS = 2200,
  localparam int GAP_W = $clog2(LINE_WORDS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             word_vld_i,
  input logic [19:0]      data_o,
  input logic             data_vld_o,
  input logic             locked_o,
  input logic             slip_o,
  input logic             line_o,
  input logic             frame_o,
  input logic             hanc_o,
  input logic             hit_w,
  input logic [OFF_W-1:0] off_w,
  input logic [GAP_W-1:0] gap_w
);
  AST_OFF_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni) off_w < OFF_W'(WORD_W)); // R5
  AST_SLIP_WRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni) slip_o |-> off_w == next_off($past(off_w))); // R5
  AST_SLIP_UNLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni) slip_o |-> !locked_o); // R4
  AST_GAP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni) gap_w < GAP_W'(LINE_WORDS)); // R4
  AST_HIT_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni) hit_w |=> locked_o); // R3
  AST_UNLOCK_KEEPS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(locked_o) |-> $stable(off_w)); // R6
  AST_IDLE_HOLDS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni) !(word_vld_i && en_i) |=> $stable(off_w)); // R11
  AST_QUIET_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni) !en_i |-> !(line_o || frame_o || hanc_o || data_vld_o)); // R10
  AST_FRAME_WITH_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni) frame_o |-> line_o); // R8
  AST_LINE_NOT_HANC: assert property (@(posedge clk_i) disable iff (!rst_ni) line_o |-> !hanc_o); // R7
  AST_HANC_NOT_TRS: assert property (@(posedge clk_i) disable iff (!rst_ni) hanc_o |-> data_o != ALL_ONES); // R9
endmodule

bind vid_word_aligner vwa_checker #(.LINE_WORDS(LINE_WORDS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .word_vld_i(word_vld_i),
  .data_o(data_o), .data_vld_o(data_vld_o), .locked_o(locked_o), .slip_o(slip_o),
  .line_o(line_o), .frame_o(frame_o), .hanc_o(hanc_o),
  .hit_w(hit_w), .off_w(off_w), .gap_w(gap_w)
);

// File: tb/tb_vid_word_aligner.sv
module tb_vid_word_aligner;
  localparam int LW = 48;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, vld = 1'b0;
  logic [19:0] raw = '0;
  logic [19:0] data_o;
  logic data_vld_o, locked_o, slip_o, line_o, frame_o, hanc_o;

  vid_word_aligner #(.LINE_WORDS(LW), .MISS_LIMIT(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .word_vld_i(vld), .word_i(raw),
    .data_o, .data_vld_o, .locked_o, .slip_o, .line_o, .frame_o, .hanc_o
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_off, m_gap, m_miss, m_pos, m_lnlo;
  bit m_lock, m_hanc_st;
  logic [19:0] m_prev;
  logic [19:0] m_hist[$];
  logic [19:0] e_data;
  bit e_vld, e_line, e_frame, e_hanc, e_slip;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_off = 0; m_gap = 0; m_miss = 0; m_pos = 0; m_lnlo = 0; m_lock = 0; m_hanc_st = 0;
      m_prev = '0; m_hist.delete();
      e_data = '0; e_vld = 0; e_line = 0; e_frame = 0; e_hanc = 0; e_slip = 0;
    end else begin
      e_slip = 0; e_vld = 0; e_line = 0; e_frame = 0; e_hanc = 0;
      if (en && vld) begin
        logic [39:0] win;
        logic [19:0] w;
        bit hit, eav;
        win = {raw, m_prev};
        w = win[m_off +: 20];
        hit = (m_hist.size() == 3) && m_hist[0] == 20'hFFFFF && m_hist[1] == 0 &&
              m_hist[2] == 0 && w[9] && (w[19:10] == w[9:0]);
        eav = hit && w[6];
        e_vld = 1; e_data = w;
        e_line = (m_pos == 2);
        e_frame = e_line && ((int'(w[5:2]) * 128 + m_lnlo) == 1);
        e_hanc = m_hanc_st && (w != 20'hFFFFF);
        if (m_pos == 1) m_lnlo = int'(w[8:2]);
        if (m_pos == 4) m_hanc_st = 1;
        else if (w == 20'hFFFFF) m_hanc_st = 0;
        if (eav) m_pos = 1;
        else if (m_pos == 4) m_pos = 0;
        else if (m_pos != 0) m_pos++;
        m_hist.push_back(w);
        if (m_hist.size() > 3) void'(m_hist.pop_front());
        if (hit) begin
          m_gap = 0; m_miss = 0; m_lock = 1;
        end else if (m_gap == LW - 1) begin
          m_gap = 0;
          if (!m_lock) begin
            m_off = (m_off + 1) % 20; e_slip = 1;
            m_hist.delete(); m_pos = 0; m_hanc_st = 0;
          end else if (m_miss == 1) begin
            m_lock = 0; m_miss = 0;
          end else m_miss++;
        end else m_gap++;
        m_prev = raw;
      end
    end
  end

  // ---------------- per-cycle comparison and counters ----------------
  int slip_cnt = 0, line_cnt = 0, frame_cnt = 0, hanc_run = 0, vld_cnt = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(locked_o == m_lock, "R6", "locked_o", locked_o, m_lock);
      check(slip_o == e_slip, "R4", "slip_o", slip_o, e_slip);
      check(data_vld_o == e_vld, "R11", "data_vld_o", data_vld_o, e_vld);
      if (e_vld) check(data_o == e_data, "R2", "data_o", data_o, e_data);
      check(line_o == e_line, "R7", "line_o", line_o, e_line);
      check(frame_o == e_frame, "R8", "frame_o", frame_o, e_frame);
      check(hanc_o == e_hanc, "R9", "hanc_o", hanc_o, e_hanc);
      slip_cnt += slip_o;
      line_cnt += line_o;
      frame_cnt += frame_o;
      vld_cnt += data_vld_o;
      if (data_vld_o) begin
        if (hanc_o) hanc_run++;
        else if (hanc_run > 0) begin
          check(hanc_run == 8, "R9", "hanc run length", hanc_run, 8);
          hanc_run = 0;
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  bit bq[$];

  task automatic push_word(logic [19:0] w);
    for (int i = 0; i < 20; i++) bq.push_back(w[i]);
  endtask

  task automatic push_junk(int n);
    for (int i = 0; i < n; i++) bq.push_back(i % 2);
  endtask

  function automatic logic [10:0] lnum_of(int i);
    case (i % 5)
      0: return 11'd1;
      1: return 11'd129;
      2: return 11'd200;
      3: return 11'd1;
      default: return 11'd1153;
    endcase
  endfunction

  task automatic push_line(int i);
    logic [10:0] n;
    n = lnum_of(i);
    push_word(20'hFFFFF); push_word('0); push_word('0); push_word({2{10'h274}});
    push_word({2{1'b1, n[6:0], 2'b00}});
    push_word({2{4'b1000, n[10:7], 2'b00}});
    push_word({2{10'h0A5}}); push_word({2{10'h14A}});
    for (int k = 0; k < 8; k++) push_word({2{10'h060 + 10'(k)}});
    push_word(20'hFFFFF); push_word('0); push_word('0); push_word({2{10'h200}});
    for (int k = 0; k < 20; k++) push_word({2{10'h040 + 10'(k)}});
  endtask

  task automatic feed();
    int n = 0;
    while (bq.size() >= 20) begin
      @(negedge clk);
      n++;
      if (n % 7 == 0) vld = 0;
      else begin
        logic [19:0] w;
        for (int i = 0; i < 20; i++) w[i] = bq.pop_front();
        raw = w; vld = 1;
      end
    end
    @(negedge clk); vld = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
    finish_run();
  end

  initial begin
    int s0, l0, f0, v0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(!locked_o && !slip_o && !data_vld_o, "R1", "status after reset", {locked_o, slip_o, data_vld_o}, 0);
    check(!line_o && !frame_o && !hanc_o, "R1", "strobes after reset", {line_o, frame_o, hanc_o}, 0);

    // phase 1: seven-bit phase, search must slip seven times then lock (R3 R4)
    en = 1;
    push_junk(7);
    for (int i = 0; i < 16; i++) push_line(i);
    feed();
    check(slip_cnt == 7, "R4", "slips to reach phase 7", slip_cnt, 7);
    check(locked_o == 1, "R3", "locked after phase 1", locked_o, 1);
    check(line_cnt > 0 && frame_cnt > 0, "R7", "line and frame seen", line_cnt, 1);

    // phase 2: no references, lock must drop (R6)
    s0 = slip_cnt;
    for (int i = 0; i < 110; i++) push_word({2{10'h050}});
    feed();
    check(locked_o == 0, "R6", "lock lost after two silent lines", locked_o, 0);

    // phase 3: new phase 3 needs a wrap 19->0 (R5)
    push_junk(16);
    for (int i = 0; i < 24; i++) push_line(i);
    feed();
    check(slip_cnt - s0 == 16, "R5", "slips through wrap", slip_cnt - s0, 16);
    check(locked_o == 1, "R3", "relocked after wrap", locked_o, 1);

    // phase 4a: disabled, nothing may come out (R10)
    l0 = line_cnt; f0 = frame_cnt; v0 = vld_cnt;
    en = 0;
    for (int i = 0; i < 4; i++) push_line(i);
    feed();
    check(line_cnt == l0 && vld_cnt == v0, "R10", "output while disabled", line_cnt - l0 + vld_cnt - v0, 0);
    check(locked_o == 1, "R10", "lock kept while disabled", locked_o, 1);

    // phase 4b: enabled again, four lines, two of them line 1 (R7 R8)
    en = 1;
    for (int i = 0; i < 4; i++) push_line(i);
    feed();
    check(line_cnt - l0 == 4, "R7", "line strobes", line_cnt - l0, 4);
    check(frame_cnt - f0 == 2, "R8", "frame strobes", frame_cnt - f0, 2);
    finish_run();
  end
endmodule